// File: doc/BRIEF.md
# Byte-Lane Mesh Packet Receiver

This block sits behind the byte deserializer of a chip-to-chip link. Each clock it takes one byte from an 8-bit data lane and one framing bit. From them it rebuilds 104-bit mesh transactions. The first byte of a frame is a control byte, and one of its bits selects a 9-byte short packet or a 13-byte long packet. When the framing bit stays high past the last byte of a packet, the link continues as a burst with no header. Only the payload bytes of the next transaction arrive, and the receiver rebuilds its destination address from the previous one.

Completed transactions are sorted into two small queues: one for reads and one for writes. Each queue drives its own wait line back to the sender. The wait line rises while enough free space remains to absorb transactions already on the wire. A frame that collapses in the middle of a packet is thrown away and leaves a sticky error flag. A separate capture mode copies the raw lane pins into a snapshot register and assembles no packets.

Top module: `pkt_rx`

## Requirements
- R1: After reset both queues are empty (`rd_valid`, `wr_valid` low), both wait lines are low, `frame_err` is low and `pin_snap` is zero.
- R2: A frame starts on the first sampled byte with `lane_frame` high while the receiver is idle. That byte is the control byte, and control bit 7 = 0 marks a short packet of 9 bytes. Bytes 1..4 form the destination address, most significant byte first. Bytes 5..8 form the data word, most significant byte first. The source field of a short packet is zero. A packet is laid out as {control[103:96], destination[95:64], data[63:32], source[31:0]}.
- R3: Control bit 7 = 1 marks a long packet of 13 bytes, whose bytes 9..12 form the source field, most significant byte first.
- R4: Control bit 0 = 1 routes a packet to the write queue; bit 0 = 0 routes it to the read queue.
- R5: A packet enters its queue only when its final byte is sampled, and it is visible at the queue head right after that clock edge and not earlier.
- R6: If `lane_frame` is still high on the byte after a packet's final byte, that byte is byte 5 of a new transaction in the same burst. The new transaction reuses the control byte and takes destination = previous destination + 8 (long) or + 4 (short). A short burst member has source zero, and a long one receives new source bytes 9..12.
- R7: If `lane_frame` drops before a packet's final byte, the partial packet is discarded and `frame_err` goes high and stays high until reset.
- R8: `wait_rd` is high exactly while the read queue's free entries are at most SLACK; `wait_wr` follows the write queue the same way, independently.
- R9: While `rx_en` is low no byte is captured and no packet is produced.
- R10: With `rx_en` high and `rx_mode` = 01, each clock stores {lane_frame, lane_data} into `pin_snap` and no packet is assembled. In other modes `pin_snap` holds its value. Only `rx_mode` = 00 assembles packets.
- R11: Each queue delivers packets in arrival order; a pop (`rd_pop`/`wr_pop`) with the queue non-empty removes the head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| rx_mode | input | 2 | 00 packet assembly, 01 pin capture, others idle |
| lane_data | input | 8 | Byte lane |
| lane_frame | input | 1 | Framing bit |
| rd_pop | input | 1 | Remove read queue head |
| wr_pop | input | 1 | Remove write queue head |
| rd_valid | output | 1 | Read queue not empty |
| rd_pkt | output | 104 | Read queue head packet |
| wr_valid | output | 1 | Write queue not empty |
| wr_pkt | output | 104 | Write queue head packet |
| wait_rd | output | 1 | Read pushback to sender |
| wait_wr | output | 1 | Write pushback to sender |
| frame_err | output | 1 | Sticky broken-frame flag |
| pin_snap | output | 9 | Captured {frame, data} in pin mode |

## Verification
The bench builds the receiver with DEPTH = 4 and SLACK = 2. With those values the read queue reaches its wait threshold after two packets, and it fills completely within a short burst. Wait rise, wait fall and head ordering across a full queue therefore all come within a few hundred cycles. The small depth also lets a three-member write burst nearly fill the write queue while the read side stays clear, which exposes any coupling between the two wait lines.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam int PKT_W     = 104;
  localparam int LONG_BIT  = 7;
  localparam int WRITE_BIT = 0;
  localparam int SHORT_END = 8;
  localparam int LONG_END  = 12;
  localparam int CONT_POS  = 5;

  localparam logic [1:0] MODE_PACKET = 2'b00;
  localparam logic [1:0] MODE_PINS   = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_LINK = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [31:0] dst;
    logic [31:0] data;
    logic [31:0] src;
  } mesh_pkt_t;
endpackage

// File: rtl/pkt_rx_rst_sync.sv
module pkt_rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pkt_rx_deframer.sv
module pkt_rx_deframer
  import pkt_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [1:0]       rx_mode,
  input  logic [7:0]       lane_data,
  input  logic             lane_frame,
  output logic             push,
  output logic [PKT_W-1:0] push_pkt,
  output logic             frame_err,
  output logic [8:0]       pin_snap
);
  rx_state_e   st_q, st_d;
  logic [3:0]  idx_q, idx_d;
  logic [7:0]  ctrl_q, ctrl_d;
  logic [31:0] dst_q, dst_d;
  logic [31:0] data_q, data_d;
  logic [31:0] src_q, src_d;
  logic        err_q, err_d;
  logic [8:0]  snap_q, snap_d;
  logic        capture, fld_en, snap_en, last_byte;
  logic [3:0]  end_idx;
  logic [31:0] addr_step;
  mesh_pkt_t   pkt_next;

  assign capture   = rx_en && (rx_mode == MODE_PACKET);
  assign snap_en   = rx_en && (rx_mode == MODE_PINS);
  assign fld_en    = capture && lane_frame;
  assign end_idx   = ctrl_q[LONG_BIT] ? 4'(LONG_END) : 4'(SHORT_END);
  assign addr_step = ctrl_q[LONG_BIT] ? 32'd8 : 32'd4;
  assign last_byte = (st_q == ST_BODY) && (idx_q == end_idx);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    ctrl_d = ctrl_q;
    dst_d  = dst_q;
    data_d = data_q;
    src_d  = src_q;
    err_d  = err_q;
    snap_d = snap_en ? {lane_frame, lane_data} : snap_q;
    push   = 1'b0;
    if (!capture) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (lane_frame) begin
            ctrl_d = lane_data;
            src_d  = '0;
            idx_d  = 4'd1;
            st_d   = ST_BODY;
          end
        end
        ST_LINK: begin
          if (lane_frame) begin
            dst_d  = dst_q + addr_step;
            data_d = {data_q[23:0], lane_data};
            src_d  = '0;
            idx_d  = 4'(CONT_POS + 1);
            st_d   = ST_BODY;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_BODY: begin
          if (!lane_frame) begin
            err_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            if (idx_q < 4'(CONT_POS))          dst_d  = {dst_q[23:0], lane_data};
            else if (idx_q <= 4'(SHORT_END))   data_d = {data_q[23:0], lane_data};
            else                               src_d  = {src_q[23:0], lane_data};
            if (last_byte) begin
              push = 1'b1;
              st_d = ST_LINK;
            end else begin
              idx_d = idx_q + 4'd1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign pkt_next = '{ctrl: ctrl_d, dst: dst_d, data: data_d, src: src_d};
  assign push_pkt = pkt_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dst_q  <= '0;
      data_q <= '0;
      src_q  <= '0;
    end else if (fld_en) begin
      ctrl_q <= ctrl_d;
      dst_q  <= dst_d;
      data_q <= data_d;
      src_q  <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= snap_d;
  end

  assign frame_err = err_q;
  assign pin_snap  = snap_q;

  AST_PUSH_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> lane_frame);                                    // R5
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !push);                                       // R9
  AST_PIN_MODE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode != MODE_PACKET) |-> !push);                     // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);                                // R7
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo #(
  parameter int WIDTH = 104,
  parameter int DEPTH = 8,
  parameter int SLACK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             valid,
  output logic             wait_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign push_ok = push && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop && (cnt_q != '0);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (!push_ok && pop_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wptr_q == AW'(i))) mem_q[i] <= din;
    end
  end

  assign dout   = mem_q[rptr_q];
  assign valid  = (cnt_q != '0);
  assign wait_o = (CW'(DEPTH) - cnt_q) <= CW'(SLACK);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CW'(DEPTH)));                         // R8
  AST_WAIT_RISE_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_o) |-> $past(push_ok));                       // R8
  AST_WAIT_FALL_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_o) |-> $past(pop_ok));                        // R8
endmodule

// File: rtl/pkt_rx.sv
module pkt_rx
  import pkt_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SLACK = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic [1:0]   rx_mode,
  input  logic [7:0]   lane_data,
  input  logic         lane_frame,
  input  logic         rd_pop,
  input  logic         wr_pop,
  output logic         rd_valid,
  output logic [103:0] rd_pkt,
  output logic         wr_valid,
  output logic [103:0] wr_pkt,
  output logic         wait_rd,
  output logic         wait_wr,
  output logic         frame_err,
  output logic [8:0]   pin_snap
);
  localparam int NQ = 2;

  logic             rst_n_int;
  logic             asm_push;
  logic [PKT_W-1:0] asm_pkt;
  logic             is_write;
  logic [NQ-1:0]    q_push, q_pop, q_valid, q_wait;
  logic [PKT_W-1:0] q_head [NQ];

  pkt_rx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  pkt_rx_deframer u_defr (
    .clk(clk), .rst_n(rst_n_int), .rx_en(rx_en), .rx_mode(rx_mode),
    .lane_data(lane_data), .lane_frame(lane_frame),
    .push(asm_push), .push_pkt(asm_pkt),
    .frame_err(frame_err), .pin_snap(pin_snap)
  );

  assign is_write  = asm_pkt[PKT_W - 8 + WRITE_BIT];
  assign q_push[0] = asm_push && !is_write;
  assign q_push[1] = asm_push && is_write;
  assign q_pop     = {wr_pop, rd_pop};

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    pkt_rx_fifo #(.WIDTH(PKT_W), .DEPTH(DEPTH), .SLACK(SLACK)) u_q (
      .clk(clk), .rst_n(rst_n_int),
      .push(q_push[g]), .din(asm_pkt), .pop(q_pop[g]),
      .dout(q_head[g]), .valid(q_valid[g]), .wait_o(q_wait[g])
    );
  end

  assign rd_valid = q_valid[0];
  assign rd_pkt   = q_head[0];
  assign wait_rd  = q_wait[0];
  assign wr_valid = q_valid[1];
  assign wr_pkt   = q_head[1];
  assign wait_wr  = q_wait[1];

  AST_ONE_QUEUE: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(q_push));                                       // R4
endmodule

// File: tb/pkt_rx_bench.sv
`timescale 1ns/1ps
module pkt_rx_bench;
  localparam int DEPTH = 4;
  localparam int SLACK = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         rx_en;
  logic [1:0]   rx_mode;
  logic [7:0]   lane_data;
  logic         lane_frame;
  logic         rd_pop, wr_pop;
  logic         rd_valid, wr_valid, wait_rd, wait_wr, frame_err;
  logic [103:0] rd_pkt, wr_pkt;
  logic [8:0]   pin_snap;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pkt_rx #(.DEPTH(DEPTH), .SLACK(SLACK)) u_pkt_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_mode(rx_mode),
    .lane_data(lane_data), .lane_frame(lane_frame),
    .rd_pop(rd_pop), .wr_pop(wr_pop),
    .rd_valid(rd_valid), .rd_pkt(rd_pkt), .wr_valid(wr_valid), .wr_pkt(wr_pkt),
    .wait_rd(wait_rd), .wait_wr(wait_wr), .frame_err(frame_err), .pin_snap(pin_snap)
  );

  task automatic chk(input string tag, input logic [103:0] act, input logic [103:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [103:0] rdq[$];
  logic [103:0] wrq[$];
  logic [7:0]   mb [13];
  int           m_st, m_pos;
  logic         m_err;
  logic [8:0]   m_snap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdq.delete(); wrq.delete();
      m_st = 0; m_pos = 0; m_err = 1'b0; m_snap = '0;
      for (int i = 0; i < 13; i++) mb[i] = '0;
    end else begin
      int nrd, nwr, last;
      logic [103:0] pk;
      logic [31:0]  a;
      logic         emit;
      emit = 1'b0;
      nrd = rdq.size(); nwr = wrq.size();
      if (rd_pop && nrd > 0) void'(rdq.pop_front());
      if (wr_pop && nwr > 0) void'(wrq.pop_front());
      if (rx_en && rx_mode == 2'b01) m_snap = {lane_frame, lane_data};
      last = mb[0][7] ? 12 : 8;
      if (!(rx_en && rx_mode == 2'b00)) m_st = 0;
      else if (m_st == 0) begin
        if (lane_frame) begin
          for (int i = 1; i < 13; i++) mb[i] = '0;
          mb[0] = lane_data; m_pos = 1; m_st = 1;
        end
      end else if (m_st == 2) begin
        if (lane_frame) begin
          a = {mb[1], mb[2], mb[3], mb[4]} + (mb[0][7] ? 32'd8 : 32'd4);
          {mb[1], mb[2], mb[3], mb[4]} = a;
          for (int i = 9; i < 13; i++) mb[i] = '0;
          mb[5] = lane_data; m_pos = 6; m_st = 1;
        end else m_st = 0;
      end else begin
        if (!lane_frame) begin
          m_err = 1'b1; m_st = 0;
        end else begin
          mb[m_pos] = lane_data;
          if (m_pos == last) begin emit = 1'b1; m_st = 2; end
          else m_pos++;
        end
      end
      if (emit) begin
        for (int i = 0; i < 13; i++) pk[103-8*i -: 8] = mb[i];
        if (mb[0][0]) begin if (nwr < DEPTH) wrq.push_back(pk); end
        else begin if (nrd < DEPTH) rdq.push_back(pk); end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 rd valid", 104'(rd_valid), 104'(rdq.size() != 0));
      if (rdq.size() != 0) chk("R2 rd head", rd_pkt, rdq[0]);
      chk("R11 wr valid", 104'(wr_valid), 104'(wrq.size() != 0));
      if (wrq.size() != 0) chk("R4 wr head", wr_pkt, wrq[0]);
      chk("R8 wait_rd", 104'(wait_rd), 104'((DEPTH - rdq.size()) <= SLACK));
      chk("R8 wait_wr", 104'(wait_wr), 104'((DEPTH - wrq.size()) <= SLACK));
      chk("R7 frame_err", 104'(frame_err), 104'(m_err));
      chk("R10 pin_snap", 104'(pin_snap), 104'(m_snap));
    end
  end

  // Stimulus helpers
  task automatic drv(input logic f, input logic [7:0] d);
    @(negedge clk); #1;
    lane_frame = f; lane_data = d;
  endtask

  task automatic send(input logic [7:0] c, input logic [31:0] d, input logic [31:0] dt,
                      input logic [31:0] s, input bit hold);
    logic [103:0] p;
    p = {c, d, dt, s};
    for (int i = 0; i <= (c[7] ? 12 : 8); i++) drv(1'b1, p[103-8*i -: 8]);
    if (!hold) drv(1'b0, 8'h00);
  endtask

  task automatic cont(input logic [31:0] dt, input logic [31:0] s, input bit lng, input bit hold);
    for (int i = 0; i < 4; i++) drv(1'b1, dt[31-8*i -: 8]);
    if (lng) for (int i = 0; i < 4; i++) drv(1'b1, s[31-8*i -: 8]);
    if (!hold) drv(1'b0, 8'h00);
  endtask

  task automatic pop_one(input bit wr);
    @(negedge clk); #1;
    if (wr) wr_pop = 1'b1; else rd_pop = 1'b1;
    @(negedge clk); #1;
    wr_pop = 1'b0; rd_pop = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk); #1;
    rd_pop = 1'b1; wr_pop = 1'b1;
    repeat (DEPTH + 1) @(negedge clk);
    #1; rd_pop = 1'b0; wr_pop = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b1; rx_mode = 2'b00;
    lane_data = '0; lane_frame = 1'b0; rd_pop = 1'b0; wr_pop = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) drv(1'b0, 8'h00);

    // R1 reset state
    chk("R1 rd_valid", 104'(rd_valid), 104'(0));
    chk("R1 wr_valid", 104'(wr_valid), 104'(0));
    chk("R1 waits", 104'({wait_rd, wait_wr}), 104'(0));
    chk("R1 err", 104'(frame_err), 104'(0));
    chk("R1 snap", 104'(pin_snap), 104'(0));

    // R2 short read, source bytes never sent; R4 routing to read side
    send(8'h00, 32'h0000_1234, 32'hA5A5_0001, 32'hDEAD_BEEF, 1'b0);
    chk("R2 short layout", rd_pkt, {8'h00, 32'h0000_1234, 32'hA5A5_0001, 32'h0});
    chk("R4 read not in write queue", 104'(wr_valid), 104'(0));
    drain();

    // R5 packet appears only after final byte
    begin
      logic [103:0] p;
      p = {8'h01, 32'h0BAD_0000, 32'h1357_9BDF, 32'h0};
      for (int i = 0; i < 8; i++) drv(1'b1, p[103-8*i -: 8]);
      drv(1'b1, p[103-64 -: 8]);
      chk("R5 not before final byte", 104'(wr_valid), 104'(0));
      drv(1'b0, 8'h00);
      chk("R5 visible after final byte", 104'(wr_valid), 104'(1));
      chk("R4 write routed", wr_pkt, p);
      chk("R4 write not in read queue", 104'(rd_valid), 104'(0));
    end
    drain();

    // R3 long read
    send(8'h80, 32'h2000_0010, 32'h1111_2222, 32'h3333_4444, 1'b0);
    chk("R3 long layout", rd_pkt, {8'h80, 32'h2000_0010, 32'h1111_2222, 32'h3333_4444});
    drain();

    // R6 long write burst
    send(8'h81, 32'h4000_0000, 32'h0000_0001, 32'h0000_0002, 1'b1);
    cont(32'h0000_0003, 32'h0000_0004, 1'b1, 1'b1);
    cont(32'h0000_0005, 32'h0000_0006, 1'b1, 1'b0);
    chk("R6 burst first", wr_pkt, {8'h81, 32'h4000_0000, 32'h1, 32'h2});
    pop_one(1'b1);
    chk("R6 burst second +8", wr_pkt, {8'h81, 32'h4000_0008, 32'h3, 32'h4});
    pop_one(1'b1);
    chk("R6 burst third +16", wr_pkt, {8'h81, 32'h4000_0010, 32'h5, 32'h6});
    drain();

    // R6 short read burst
    send(8'h00, 32'h0000_0100, 32'h0000_0007, 32'h0, 1'b1);
    cont(32'h0000_0008, 32'h0, 1'b0, 1'b0);
    pop_one(1'b0);
    chk("R6 short burst +4", rd_pkt, {8'h00, 32'h0000_0104, 32'h8, 32'h0});
    drain();

    // R7 frame drop mid-packet
    drv(1'b1, 8'h01); drv(1'b1, 8'h22); drv(1'b1, 8'h33); drv(1'b0, 8'h00);
    drv(1'b0, 8'h00);
    chk("R7 err set", 104'(frame_err), 104'(1));
    chk("R7 nothing queued", 104'({rd_valid, wr_valid}), 104'(0));
    send(8'h00, 32'h0000_0200, 32'h9, 32'h0, 1'b0);
    chk("R7 err sticky", 104'(frame_err), 104'(1));
    chk("R7 later packet ok", rd_pkt, {8'h00, 32'h0000_0200, 32'h9, 32'h0});
    drain();

    // R9 receive disabled
    @(negedge clk); #1 rx_en = 1'b0;
    send(8'h00, 32'h0000_0300, 32'hA, 32'h0, 1'b0);
    chk("R9 disabled no packet", 104'({rd_valid, wr_valid}), 104'(0));
    @(negedge clk); #1 rx_en = 1'b1;

    // R10 pin capture mode
    @(negedge clk); #1 rx_mode = 2'b01; lane_frame = 1'b1; lane_data = 8'h5A;
    @(negedge clk); #1 rx_mode = 2'b00; lane_frame = 1'b0; lane_data = 8'h00;
    drv(1'b1, 8'hC3);
    chk("R10 snapshot", 104'(pin_snap), 104'(9'h15A));
    drv(1'b0, 8'h00);
    chk("R10 held in packet mode", 104'(pin_snap), 104'(9'h15A));
    drv(1'b0, 8'h00);
    @(negedge clk); #1 rx_mode = 2'b01;
    send(8'h00, 32'h0000_0400, 32'hB, 32'h0, 1'b0);
    @(negedge clk); #1 rx_mode = 2'b00;
    chk("R10 no packet in pin mode", 104'({rd_valid, wr_valid}), 104'(0));

    // R8 threshold, independent lines; R11 ordering
    send(8'h00, 32'h0000_0500, 32'hC1, 32'h0, 1'b0);
    chk("R8 one entry no wait", 104'(wait_rd), 104'(0));
    send(8'h00, 32'h0000_0504, 32'hC2, 32'h0, 1'b0);
    chk("R8 wait_rd at threshold", 104'(wait_rd), 104'(1));
    chk("R8 wait_wr independent", 104'(wait_wr), 104'(0));
    send(8'h00, 32'h0000_0508, 32'hC3, 32'h0, 1'b0);
    send(8'h00, 32'h0000_050C, 32'hC4, 32'h0, 1'b0);
    chk("R8 full still waiting", 104'(wait_rd), 104'(1));
    for (int k = 1; k <= 4; k++) begin
      chk("R11 order", rd_pkt[63:32], 104'(32'hC0 + k));
      pop_one(1'b0);
    end
    chk("R8 wait_rd released", 104'(wait_rd), 104'(0));
    chk("R11 empty after pops", 104'(rd_valid), 104'(0));

    repeat (4) drv(1'b0, 8'h00);
    summary();
    $finish;
  end
endmodule